// File: doc/BRIEF.md
# Dual-Channel Pointer-Indexed Register File

This block is the host-facing register interface of a two-channel serial controller. The host sees four byte-wide ports, one data port and one control port per channel. Each channel has eight write registers and three read registers. They are reached indirectly: the low three bits of write register 0 act as a pointer, and the next control access goes to the register that pointer selects. After that access the pointer falls back to 0.

The block stores the write registers and presents them to the serial engines as a flat configuration bus. It keeps a one-character receive buffer and a one-character transmit buffer per channel, each with a handshake flag. A command code in write register 0 wipes one channel, and the global reset wipes both. The serial shifting, interrupt vectoring and DMA sit outside this block.

Top module: `rfc_dual_regfile`

## Requirements
- R1: After the global reset every write register of both channels reads 0, no received character is flagged, both transmit buffers are empty, and a control read of register 0 returns 0x04.
- R2: host_addr bit 0 selects the port: 0 is data and 1 is control. The bits above bit 0 give the channel number. An access to one channel never changes the other channel's registers or buffers.
- R3: A control write stores host_wdata in write register N, where N is the pointer (write register 0 bits 2:0).
- R4: After any control read or write while the pointer is nonzero, the pointer returns to 0. Bits 7:3 of write register 0 keep their value.
- R5: A control read returns read register 0 when the pointer is 0. It returns 0x00 when the pointer is 1, the contents of write register 2 when the pointer is 2, and 0x00 when the pointer is 3 to 7.
- R6: A write to write register 0 whose bits 5:3 equal 011 clears that channel only. All its write registers, including the pointer, go to 0, its receive flag clears and its transmit buffer becomes empty.
- R7: A one-cycle rx_valid pulse latches the character and sets read register 0 bit 0 and rx_ready. A data-port read returns the latched character and clears the flag. If a new character arrives in the same cycle as that read, the flag stays set and the new character is kept.
- R8: A data-port write while the transmit buffer is empty loads tx_char and clears read register 0 bit 2 and tx_empty. A tx_take pulse while the buffer is full sets both again.
- R9: A data-port write while the transmit buffer is full is ignored. tx_char and tx_empty keep their values.
- R10: Read register 0 has bit 0 as the receive flag and bit 2 as the transmit-empty flag. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host select |
| host_addr | input | 2 | Bit 0: data (0) or control (1); bit 1: channel |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| rx_valid | input | 2 | Per-channel received-character strobe |
| rx_char | input | 16 | Per-channel received character, channel c at [8c+7:8c] |
| tx_take | input | 2 | Per-channel pulse: engine took the transmit character |
| tx_char | output | 16 | Per-channel transmit character |
| tx_empty | output | 2 | Per-channel transmit buffer empty |
| rx_ready | output | 2 | Per-channel received character available |
| cfg_regs | output | 128 | Write registers, channel c register r at [(8c+r)*8 +: 8] |

## Verification
The bench builds the block with its default parameters: two channels, eight 8-bit write registers and a 3-bit pointer. With this configuration every pointer value in both channels can be swept in full. For each pointer value the bench writes and reads and checks both the target register and the pointer fallback. This covers every read-register select, including the invalid ones. The small buffers also allow short, complete sequences of receive, transmit, busy-write, per-channel clear and global reset on each channel. Each sequence includes a check that the other channel stayed untouched.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_WR     = 8;
  localparam int NUM_RR     = 3;
  localparam int NUM_CH     = 2;
  localparam int CMD_LO     = 3;
  localparam int CMD_HI     = 5;
  localparam logic [CMD_HI-CMD_LO:0] CLR_CODE = 3'b011;
  localparam int RR0_RX_BIT = 0;
  localparam int RR0_TX_BIT = 2;
  localparam int VEC_IDX    = 2;
endpackage

// File: rtl/rfc_host_decode.sv
module rfc_host_decode #(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH) + 1
) (
  input  logic          host_sel,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [NCH-1:0] ctrl_wr,
  output logic [NCH-1:0] ctrl_rd,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] data_rd
);
  localparam int CW = AW - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit        = host_sel && (host_addr[AW-1:1] == CW'(c));
    assign ctrl_wr[c] = hit &&  host_addr[0] && host_wr;
    assign ctrl_rd[c] = hit &&  host_addr[0] && host_rd;
    assign data_wr[c] = hit && !host_addr[0] && host_wr;
    assign data_rd[c] = hit && !host_addr[0] && host_rd;
  end
endmodule

// File: rtl/rfc_chan_regs.sv
module rfc_chan_regs
  import rfc_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NWR = NUM_WR,
  parameter int PW  = $clog2(NWR)
) (
  input  logic                   clk,
  input  logic                   srst_n,
  input  logic                   ctrl_wr,
  input  logic                   ctrl_rd,
  input  logic [DW-1:0]          wdata,
  output logic [NWR-1:0][DW-1:0] wr_q,
  output logic [PW-1:0]          ptr,
  output logic                   chan_clr
);
  logic [NWR-1:0][DW-1:0] wr_d;
  logic                   wr_en;

  assign ptr   = wr_q[0][PW-1:0];
  assign wr_en = ctrl_wr | ctrl_rd;

  always_comb begin
    wr_d     = wr_q;
    chan_clr = 1'b0;
    if (ctrl_wr) begin
      if (ptr == '0) begin
        if (wdata[CMD_HI:CMD_LO] == CLR_CODE) begin
          chan_clr = 1'b1;
          wr_d     = '0;
        end else begin
          wr_d[0] = wdata;
        end
      end else begin
        wr_d[ptr]        = wdata;
        wr_d[0][PW-1:0]  = '0;
      end
    end else if (ctrl_rd && (ptr != '0)) begin
      wr_d[0][PW-1:0] = '0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wr_q <= '0;
    end else if (wr_en) begin
      wr_q <= wr_d;
    end
  end
endmodule

// File: rtl/rfc_chan_buf.sv
module rfc_chan_buf
  import rfc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          clr,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_take,
  output logic [DW-1:0] rx_buf_q,
  output logic          rx_avail_q,
  output logic [DW-1:0] tx_buf_q,
  output logic          tx_empty_q
);
  logic [DW-1:0] rx_buf_d, tx_buf_d;
  logic          rx_avail_d, tx_empty_d;
  logic          buf_en;

  assign buf_en = clr | rx_valid | data_rd | data_wr | tx_take;

  always_comb begin
    rx_buf_d   = rx_buf_q;
    rx_avail_d = rx_avail_q;
    tx_buf_d   = tx_buf_q;
    tx_empty_d = tx_empty_q;
    if (clr) begin
      rx_buf_d   = '0;
      rx_avail_d = 1'b0;
      tx_buf_d   = '0;
      tx_empty_d = 1'b1;
    end else begin
      if (data_rd) begin
        rx_avail_d = 1'b0;
      end
      if (rx_valid) begin
        rx_buf_d   = rx_char;
        rx_avail_d = 1'b1;
      end
      if (tx_empty_q) begin
        if (data_wr) begin
          tx_buf_d   = wdata;
          tx_empty_d = 1'b0;
        end
      end else if (tx_take) begin
        tx_empty_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rx_buf_q   <= '0;
      rx_avail_q <= 1'b0;
      tx_buf_q   <= '0;
      tx_empty_q <= 1'b1;
    end else if (buf_en) begin
      rx_buf_q   <= rx_buf_d;
      rx_avail_q <= rx_avail_d;
      tx_buf_q   <= tx_buf_d;
      tx_empty_q <= tx_empty_d;
    end
  end
endmodule

// File: rtl/rfc_chan_rdmux.sv
module rfc_chan_rdmux
  import rfc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = 3
) (
  input  logic          ctrl_rd,
  input  logic          data_rd,
  input  logic [PW-1:0] ptr,
  input  logic          rx_avail,
  input  logic          tx_empty,
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] rx_buf,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (data_rd) begin
      rdata = rx_buf;
    end else if (ctrl_rd) begin
      case (ptr)
        PW'(0): begin
          rdata[RR0_RX_BIT] = rx_avail;
          rdata[RR0_TX_BIT] = tx_empty;
        end
        PW'(1):  rdata = '0;
        PW'(2):  rdata = vec;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rfc_dual_regfile.sv
module rfc_dual_regfile
  import rfc_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int NWR = NUM_WR,
  parameter int AW  = $clog2(NCH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_sel,
  input  logic [AW-1:0]         host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  input  logic [NCH-1:0]        rx_valid,
  input  logic [NCH*DW-1:0]     rx_char,
  input  logic [NCH-1:0]        tx_take,
  output logic [NCH*DW-1:0]     tx_char,
  output logic [NCH-1:0]        tx_empty,
  output logic [NCH-1:0]        rx_ready,
  output logic [NCH*NWR*DW-1:0] cfg_regs
);
  localparam int PW = $clog2(NWR);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  logic [NCH-1:0] ctrl_wr, ctrl_rd, data_wr, data_rd;

  rfc_host_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .host_sel (host_sel),
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .ctrl_wr  (ctrl_wr),
    .ctrl_rd  (ctrl_rd),
    .data_wr  (data_wr),
    .data_rd  (data_rd)
  );

  logic [NCH-1:0][DW-1:0] ch_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NWR-1:0][DW-1:0] wr_q;
    logic [PW-1:0]          ptr;
    logic                   chan_clr;
    logic [DW-1:0]          rx_buf;
    logic                   rx_avail;
    logic [DW-1:0]          tx_buf;
    logic                   tx_emp;

    rfc_chan_regs #(.DW(DW), .NWR(NWR), .PW(PW)) u_regs (
      .clk     (clk),
      .srst_n  (srst_n),
      .ctrl_wr (ctrl_wr[c]),
      .ctrl_rd (ctrl_rd[c]),
      .wdata   (host_wdata),
      .wr_q    (wr_q),
      .ptr     (ptr),
      .chan_clr(chan_clr)
    );

    rfc_chan_buf #(.DW(DW)) u_buf (
      .clk       (clk),
      .srst_n    (srst_n),
      .clr       (chan_clr),
      .rx_valid  (rx_valid[c]),
      .rx_char   (rx_char[c*DW +: DW]),
      .data_rd   (data_rd[c]),
      .data_wr   (data_wr[c]),
      .wdata     (host_wdata),
      .tx_take   (tx_take[c]),
      .rx_buf_q  (rx_buf),
      .rx_avail_q(rx_avail),
      .tx_buf_q  (tx_buf),
      .tx_empty_q(tx_emp)
    );

    rfc_chan_rdmux #(.DW(DW), .PW(PW)) u_rd (
      .ctrl_rd (ctrl_rd[c]),
      .data_rd (data_rd[c]),
      .ptr     (ptr),
      .rx_avail(rx_avail),
      .tx_empty(tx_emp),
      .vec     (wr_q[VEC_IDX]),
      .rx_buf  (rx_buf),
      .rdata   (ch_rdata[c])
    );

    assign tx_char[c*DW +: DW]              = tx_buf;
    assign tx_empty[c]                      = tx_emp;
    assign rx_ready[c]                      = rx_avail;
    assign cfg_regs[c*NWR*DW +: NWR*DW]     = wr_q;
  end

  always_comb begin
    host_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      host_rdata = host_rdata | ch_rdata[c];
    end
  end
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int NWR = 8,
  parameter int AW  = 2
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic                  host_sel,
  input logic [AW-1:0]         host_addr,
  input logic                  host_wr,
  input logic                  host_rd,
  input logic [DW-1:0]         host_rdata,
  input logic [NCH-1:0]        rx_valid,
  input logic [NCH-1:0]        tx_take,
  input logic [NCH*DW-1:0]     tx_char,
  input logic [NCH-1:0]        tx_empty,
  input logic [NCH-1:0]        rx_ready,
  input logic [NCH*NWR*DW-1:0] cfg_regs
);
  localparam int PW = $clog2(NWR);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [AW-1:0] CTRL_A = AW'(2*c + 1);
    localparam logic [AW-1:0] DATA_A = AW'(2*c);
    logic [PW-1:0] ptr_c;
    logic          ctl_hit, dat_hit;
    assign ptr_c   = cfg_regs[c*NWR*DW +: PW];
    assign ctl_hit = host_sel && (host_addr == CTRL_A);
    assign dat_hit = host_sel && (host_addr == DATA_A);

    // R5
    a_r5_bad_ptr_zero: assert property (@(posedge clk) disable iff (!srst_n)
      (ctl_hit && host_rd && (ptr_c >= PW'(3))) |-> (host_rdata == '0));

    // R4
    a_r4_ptr_returns: assert property (@(posedge clk) disable iff (!srst_n)
      (ctl_hit && (host_wr || host_rd) && (ptr_c != '0)) |=> (ptr_c == '0));

    // R7
    a_r7_rx_sets_ready: assert property (@(posedge clk) disable iff (!srst_n)
      (rx_valid[c] && !(ctl_hit && host_wr)) |=> rx_ready[c]);

    // R8
    a_r8_take_empties: assert property (@(posedge clk) disable iff (!srst_n)
      (tx_take[c] && !tx_empty[c]) |=> tx_empty[c]);

    // R9
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!srst_n)
      (dat_hit && host_wr && !tx_empty[c] && !tx_take[c])
        |=> ($stable(tx_char[c*DW +: DW]) && !tx_empty[c]));
  end
endmodule

bind rfc_dual_regfile rfc_checker #(.NCH(NCH), .DW(DW), .NWR(NWR), .AW(AW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .host_sel  (host_sel),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_rdata(host_rdata),
  .rx_valid  (rx_valid),
  .tx_take   (tx_take),
  .tx_char   (tx_char),
  .tx_empty  (tx_empty),
  .rx_ready  (rx_ready),
  .cfg_regs  (cfg_regs)
);

// File: tb/test_rfc_dual_regfile.sv
`timescale 1ns/1ps
module test_rfc_dual_regfile;
  localparam int NCH = 2, DW = 8, NWR = 8, AW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic host_sel, host_wr, host_rd;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic [NCH-1:0] rx_valid, tx_take, tx_empty, rx_ready;
  logic [NCH*DW-1:0] rx_char, tx_char;
  logic [NCH*NWR*DW-1:0] cfg_regs;

  always #2 clk = ~clk;

  rfc_dual_regfile i_rfc_dual_regfile (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .tx_take(tx_take), .tx_char(tx_char), .tx_empty(tx_empty),
    .rx_ready(rx_ready), .cfg_regs(cfg_regs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_wr [NCH][NWR];
  logic [DW-1:0] rd;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] reg_of(int c, int r);
    return cfg_regs[(c*NWR + r)*DW +: DW];
  endfunction

  task automatic hwrite(int c, bit ctl, logic [DW-1:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = AW'(2*c + (ctl ? 1 : 0)); host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hread(int c, bit ctl, output logic [DW-1:0] d);
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_addr = AW'(2*c + (ctl ? 1 : 0));
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 0; host_rd = 0;
  endtask

  task automatic send_rx(int c, logic [DW-1:0] ch);
    @(negedge clk);
    rx_valid[c] = 1; rx_char[c*DW +: DW] = ch;
    @(negedge clk);
    rx_valid[c] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NWR; r++) exp_wr[c][r] = '0;
  endtask

  task automatic chk_chan_regs(string req, int c);
    for (int r = 0; r < NWR; r++) chk(req, reg_of(c, r), exp_wr[c][r]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_sel = 0; host_wr = 0; host_rd = 0; host_addr = '0;
    host_wdata = '0; rx_valid = '0; rx_char = '0; tx_take = '0;
    do_reset();

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      chk_chan_regs("R1", c);
      chk("R1 tx_empty", tx_empty[c], 1);
      chk("R1 rx_ready", rx_ready[c], 0);
      hread(c, 1, rd);
      chk("R1 rr0", rd, 8'h04);
    end

    // R3/R4 write sweep over every pointer; R2 isolation
    for (int c = 0; c < NCH; c++) begin
      for (int p = 1; p < NWR; p++) begin
        logic [DW-1:0] v;
        v = DW'(p * 8'h23 + c * 8'h5A + 1);
        hwrite(c, 1, DW'(p));
        hwrite(c, 1, v);
        exp_wr[c][p] = v;
        chk("R3 target", reg_of(c, p), v);
        chk("R4 ptr back", reg_of(c, 0), 8'h00);
      end
      if (c == 0) chk_chan_regs("R2 other chan", 1);
    end
    chk_chan_regs("R3 ch0", 0);

    // R5/R4 read sweep over every pointer, upper WR0 bits kept
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < NWR; p++) begin
        logic [DW-1:0] e;
        hwrite(c, 1, DW'(8'h40 | p));
        hread(c, 1, rd);
        e = (p == 0) ? 8'h04 : (p == 2) ? exp_wr[c][2] : 8'h00;
        chk("R5 read select", rd, e);
        chk("R4 upper kept", reg_of(c, 0), 8'h40);
      end
      exp_wr[c][0] = 8'h40;
    end

    // R7 receive path; R10 rr0 bits
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [DW-1:0] ch;
        ch = DW'(8'h30 + k * 37 + c);
        send_rx(c, ch);
        chk("R7 rx_ready", rx_ready[c], 1);
        chk("R2 other rx", rx_ready[1-c], 0);
        hread(c, 1, rd);
        chk("R10 rr0 rx", rd, 8'h05);
        hread(c, 0, rd);
        chk("R7 data", rd, ch);
        chk("R7 cleared", rx_ready[c], 0);
      end
    end
    // R7 new char in same cycle as the read
    send_rx(0, 8'hA1);
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_addr = 2'd0;
    rx_valid[0] = 1; rx_char[7:0] = 8'hB2;
    #1 rd = host_rdata;
    @(negedge clk);
    host_sel = 0; host_rd = 0; rx_valid[0] = 0;
    chk("R7 old char", rd, 8'hA1);
    chk("R7 flag kept", rx_ready[0], 1);
    hread(0, 0, rd);
    chk("R7 new char", rd, 8'hB2);

    // R8/R9 transmit path
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [DW-1:0] d;
        d = DW'(8'h61 + k * 19 + c * 7);
        hwrite(c, 0, d);
        chk("R8 tx_empty", tx_empty[c], 0);
        chk("R8 tx_char", tx_char[c*DW +: DW], d);
        hread(c, 1, rd);
        chk("R10 rr0 busy", rd, 8'h00);
        hwrite(c, 0, ~d);
        chk("R9 char kept", tx_char[c*DW +: DW], d);
        chk("R9 still full", tx_empty[c], 0);
        chk("R2 other tx", tx_empty[1-c], 1);
        @(negedge clk); tx_take[c] = 1;
        @(negedge clk); tx_take[c] = 0;
        chk("R8 taken", tx_empty[c], 1);
        hread(c, 1, rd);
        chk("R8 rr0 empty", rd, 8'h04);
      end
    end

    // R6 per-channel clear
    send_rx(0, 8'h11);
    send_rx(1, 8'h22);
    hwrite(0, 0, 8'h77);
    hwrite(1, 0, 8'h88);
    hwrite(0, 1, 8'h18);
    for (int r = 0; r < NWR; r++) exp_wr[0][r] = '0;
    chk_chan_regs("R6 ch0 cleared", 0);
    chk("R6 rx cleared", rx_ready[0], 0);
    chk("R6 tx emptied", tx_empty[0], 1);
    chk_chan_regs("R6 ch1 kept", 1);
    chk("R6 ch1 rx kept", rx_ready[1], 1);
    chk("R6 ch1 tx kept", tx_empty[1], 0);
    hwrite(1, 1, 8'h1B);
    for (int r = 0; r < NWR; r++) exp_wr[1][r] = '0;
    chk_chan_regs("R6 ch1 cleared", 1);
    chk("R6 ch1 rx", rx_ready[1], 0);
    chk("R6 ch1 tx", tx_empty[1], 1);

    // R1 global reset after activity
    hwrite(0, 1, 8'h03);
    hwrite(0, 1, 8'hC3);
    hwrite(1, 0, 8'h55);
    send_rx(1, 8'h66);
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      chk_chan_regs("R1 global", c);
      chk("R1 g tx", tx_empty[c], 1);
      chk("R1 g rx", rx_ready[c], 0);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule